// File: doc/BRIEF.md
# Timer with Shared Assignable Prescaler

This block is an 8-bit up-counting timer paired with a watchdog counter. The two share one power-of-two prescaler, and only one of them can use it at a time. When the prescaler belongs to the watchdog, the timer advances once per source event. When it belongs to the timer, the watchdog advances once per internal instruction tick.

The timer's count source is either the internal instruction tick or transitions on an external pin. The external pin passes through a two-flop synchronizer before edge detection. A 6-bit control input selects the source, the active edge, the prescaler's owner and a 3-bit rate code. The prescaler count is never visible outside the block.

On a rollover from 0xFF to 0x00, the timer emits a one-cycle overflow pulse that feeds an interrupt flag. The watchdog emits a one-cycle timeout pulse when it wraps past its terminal count. Software can write the timer value through a register-bus write port and can restart the watchdog with a clear input.

Top module: `tmr_shared_prescale`

## Requirements
- R1: After reset, `count` is 0x00 and `ovfPulse` and `wdtTimeout` are low.
- R2: With `ctrlIn[3]`=0 (internal source) and `ctrlIn[5]`=1 (prescaler owned by the watchdog), `count` rises by one for every cycle in which `tickIn` is high. With no tick and no write, it holds.
- R3: With `ctrlIn[5]`=0 (prescaler owned by the timer), rate code n in `ctrlIn[2:0]` makes `count` rise once per 2^(n+1) source events.
- R4: With `ctrlIn[3]`=1 the source is the external pin and `tickIn` has no effect on `count`. `ctrlIn[4]`=0 selects low-to-high transitions and `ctrlIn[4]`=1 selects high-to-low transitions. A transition of the other polarity has no effect.
- R5: An active transition on `extPin` applied before clock edge k changes `count` at edge k+2. The delay comes from two synchronizer flops and one edge-detect flop.
- R6: A step from 0xFF wraps `count` to 0x00. `ovfPulse` is high for exactly the cycle in which `count` first reads 0x00.
- R7: `wrEn` loads `wrData` into `count` at the next edge. The load takes priority over a coincident count step, and it clears the prescaler count.
- R8: Any change of `ctrlIn[5]` clears the prescaler count.
- R9: With `ctrlIn[5]`=0 the watchdog advances on every `tickIn`. `wdtTimeout` is high for one cycle after the 2^WDT_W-th step following a clear.
- R10: With `ctrlIn[5]`=1 the watchdog advances once per 2^n ticks for rate code n. Code 0 means every tick.
- R11: `wdtClr` resets both the watchdog and the prescaler. It takes priority over a coincident terminal step, so no timeout pulse follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tickIn | input | 1 | Internal instruction tick, one cycle per tick |
| extPin | input | 1 | External count pin, asynchronous |
| ctrlIn | input | 6 | [5] prescaler to watchdog, [4] falling edge, [3] external source, [2:0] rate |
| wrEn | input | 1 | Timer write strobe |
| wrData | input | TMR_W | Timer write value |
| wdtClr | input | 1 | Watchdog and prescaler clear |
| count | output | TMR_W | Timer value |
| ovfPulse | output | 1 | One-cycle timer rollover pulse |
| wdtTimeout | output | 1 | One-cycle watchdog timeout pulse |

## Verification
Two pairs of events can land on the same edge. A timer write can coincide with a count step, and a watchdog clear can coincide with the watchdog's terminal step.

The bench creates the first by raising `tickIn` and `wrEn` in the same cycle, and expects the written value with no increment. It creates the second by running the watchdog to one step short of terminal and then asserting `tickIn` and `wdtClr` together. It then expects no timeout pulse, followed by a full 2^WDT_W steps before the next timeout.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int RATE_W = 3;
  localparam int PRE_W  = 2 ** RATE_W;

  typedef struct packed {
    logic              divToWdt;
    logic              fallEdge;
    logic              srcExt;
    logic [RATE_W-1:0] rate;
  } ctrl_t;

  typedef struct packed {
    logic tmrStep;
    logic tmrLoad;
    logic wdtStep;
    logic wdtClear;
  } strobe_t;
endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) chain[0] <= 1'b0;
          else       chain[0] <= din;
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) chain[i] <= 1'b0;
          else       chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    tickIn,
  input  logic    extPin,
  input  ctrl_t   ctrl,
  input  logic    wrEn,
  input  logic    wdtClr,
  output strobe_t stb
);
  localparam int SHIFT_W = RATE_W + 1;

  logic             extSync;
  logic             extPrev;
  logic             riseEv;
  logic             fallEv;
  logic             srcEv;
  logic             divPrev;
  logic             assignChg;
  logic             presClr;
  logic             presEv;
  logic             presHit;
  logic [SHIFT_W-1:0] shiftAmt;
  logic [PRE_W-1:0] presMask;
  logic [PRE_W-1:0] presCnt;

  tmr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din (extPin),
    .dout(extSync)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extPrev <= 1'b0;
      divPrev <= 1'b0;
    end else begin
      extPrev <= extSync;
      divPrev <= ctrl.divToWdt;
    end
  end

  assign riseEv    = extSync & ~extPrev;
  assign fallEv    = ~extSync & extPrev;
  assign srcEv     = ctrl.srcExt ? (ctrl.fallEdge ? fallEv : riseEv) : tickIn;
  assign assignChg = ctrl.divToWdt ^ divPrev;
  assign presClr   = wrEn | wdtClr | assignChg;

  // The watchdog divides by 2^n, the timer by 2^(n+1).
  assign shiftAmt = ctrl.divToWdt ? {1'b0, ctrl.rate}
                                  : {1'b0, ctrl.rate} + SHIFT_W'(1);
  assign presMask = ~({PRE_W{1'b1}} << shiftAmt);

  assign presEv  = ctrl.divToWdt ? tickIn : srcEv;
  assign presHit = presEv & ((presCnt & presMask) == presMask) & ~presClr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       presCnt <= '0;
    else if (presClr) presCnt <= '0;
    else if (presEv)  presCnt <= presCnt + PRE_W'(1);
  end

  always_comb begin
    stb          = '0;
    stb.tmrLoad  = wrEn;
    stb.wdtClear = wdtClr;
    stb.tmrStep  = (ctrl.divToWdt ? srcEv : presHit) & ~wrEn;
    stb.wdtStep  = (ctrl.divToWdt ? presHit : tickIn) & ~wdtClr;
  end
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int TMR_W = 8,
  parameter int WDT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [TMR_W-1:0] wrData,
  output logic [TMR_W-1:0] count,
  output logic             ovfPulse,
  output logic             wdtTimeout
);
  logic [WDT_W-1:0] wdtCnt;
  logic             tmrTop;
  logic             wdtTop;

  assign tmrTop = (count == {TMR_W{1'b1}});
  assign wdtTop = (wdtCnt == {WDT_W{1'b1}});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count    <= '0;
      ovfPulse <= 1'b0;
    end else begin
      ovfPulse <= 1'b0;
      if (stb.tmrLoad) begin
        count <= wrData;
      end else if (stb.tmrStep) begin
        count    <= count + TMR_W'(1);
        ovfPulse <= tmrTop;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdtCnt     <= '0;
      wdtTimeout <= 1'b0;
    end else begin
      wdtTimeout <= 1'b0;
      if (stb.wdtClear) begin
        wdtCnt <= '0;
      end else if (stb.wdtStep) begin
        wdtCnt     <= wdtCnt + WDT_W'(1);
        wdtTimeout <= wdtTop;
      end
    end
  end
endmodule

// File: rtl/tmr_shared_prescale.sv
module tmr_shared_prescale
  import tmr_pkg::*;
#(
  parameter int TMR_W       = 8,
  parameter int WDT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickIn,
  input  logic             extPin,
  input  logic [5:0]       ctrlIn,
  input  logic             wrEn,
  input  logic [TMR_W-1:0] wrData,
  input  logic             wdtClr,
  output logic [TMR_W-1:0] count,
  output logic             ovfPulse,
  output logic             wdtTimeout
);
  ctrl_t   ctrl;
  strobe_t stb;

  assign ctrl.divToWdt = ctrlIn[5];
  assign ctrl.fallEdge = ctrlIn[4];
  assign ctrl.srcExt   = ctrlIn[3];
  assign ctrl.rate     = ctrlIn[2:0];

  tmr_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .tickIn(tickIn),
    .extPin(extPin),
    .ctrl  (ctrl),
    .wrEn  (wrEn),
    .wdtClr(wdtClr),
    .stb   (stb)
  );

  tmr_datapath #(.TMR_W(TMR_W), .WDT_W(WDT_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .wrData    (wrData),
    .count     (count),
    .ovfPulse  (ovfPulse),
    .wdtTimeout(wdtTimeout)
  );
endmodule

// File: rtl/tmr_shared_prescale_chk.sv
module tmr_shared_prescale_chk #(
  parameter int TMR_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             tickIn,
  input logic             srcSel,
  input logic             divSel,
  input logic             wrEn,
  input logic [TMR_W-1:0] wrData,
  input logic             wdtClr,
  input logic [TMR_W-1:0] count,
  input logic             ovfPulse,
  input logic             wdtTimeout
);
  p_load_r7: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> count == $past(wrData));

  p_ovf_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    ovfPulse |-> count == '0);

  p_ovf_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    ovfPulse |=> !ovfPulse);

  p_clr_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    wdtClr |=> !wdtTimeout);

  p_wdt_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    wdtTimeout |=> !wdtTimeout);

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && !tickIn && !srcSel && divSel) |=> $stable(count));

  p_step_one_r3: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> (count == $past(count) || count == $past(count) + TMR_W'(1)));
endmodule

bind tmr_shared_prescale tmr_shared_prescale_chk #(.TMR_W(TMR_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .tickIn    (tickIn),
  .srcSel    (ctrlIn[3]),
  .divSel    (ctrlIn[5]),
  .wrEn      (wrEn),
  .wrData    (wrData),
  .wdtClr    (wdtClr),
  .count     (count),
  .ovfPulse  (ovfPulse),
  .wdtTimeout(wdtTimeout)
);

// File: tb/sim_tmr_shared_prescale.sv
`timescale 1ns/1ps
module sim_tmr_shared_prescale;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickIn = 1'b0;
  logic       extPin = 1'b0;
  logic [5:0] ctrlIn = 6'h00;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       wdtClr = 1'b0;
  logic [7:0] count;
  logic       ovfPulse;
  logic       wdtTimeout;

  int nVec = 0;
  int nBad = 0;
  int cyc  = 0;

  always #2 clk = ~clk;

  tmr_shared_prescale u0 (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .extPin(extPin), .ctrlIn(ctrlIn),
    .wrEn(wrEn), .wrData(wrData), .wdtClr(wdtClr),
    .count(count), .ovfPulse(ovfPulse), .wdtTimeout(wdtTimeout)
  );

  // {ctrl, preload, ticks, expected count}
  localparam logic [39:0] VEC [6] = '{
    {8'h20, 8'h10, 16'd5,   8'h15},
    {8'h00, 8'h00, 16'd7,   8'h03},
    {8'h02, 8'h20, 16'd20,  8'h22},
    {8'h07, 8'h05, 16'd300, 8'h06},
    {8'h20, 8'hFE, 16'd3,   8'h01},
    {8'h01, 8'hF0, 16'd64,  8'h00}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic setCtrl(input logic [5:0] v);
    @(negedge clk); ctrlIn = v;
  endtask

  task automatic writeTmr(input logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tickIn = 1'b1;
    end
    @(negedge clk); tickIn = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finishRun;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nVec++; nBad++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      finishRun();
    end
  end

  initial begin
    idle(3);
    check("R1 count", count, 0);
    check("R1 ovf", ovfPulse, 0);
    check("R1 wdt", wdtTimeout, 0);
    rstN = 1'b1;
    idle(2);

    // R2 / R3 table walk
    for (int v = 0; v < 6; v++) begin
      setCtrl(VEC[v][37:32]);
      writeTmr(VEC[v][31:24]);
      ticks(int'(VEC[v][23:8]));
      check(VEC[v][37] ? "R2 undivided" : "R3 prescaled", count, VEC[v][7:0]);
    end

    // R6 overflow pulse
    setCtrl(6'h20);
    writeTmr(8'hFF);
    ticks(1);
    check("R6 wrap", count, 0);
    check("R6 pulse", ovfPulse, 1);
    idle(1);
    check("R6 pulse ends", ovfPulse, 0);

    // R7 write beats coincident step
    writeTmr(8'h33);
    @(negedge clk); tickIn = 1'b1; wrEn = 1'b1; wrData = 8'h40;
    @(negedge clk); tickIn = 1'b0; wrEn = 1'b0;
    check("R7 write priority", count, 8'h40);

    // R7 write clears prescaler
    setCtrl(6'h01);
    writeTmr(8'h00);
    ticks(3);
    writeTmr(8'h50);
    ticks(3);
    check("R7 prescaler cleared", count, 8'h50);
    ticks(1);
    check("R7 step after clear", count, 8'h51);

    // R8 assignment change clears prescaler
    writeTmr(8'h00);
    ticks(3);
    setCtrl(6'h21);
    setCtrl(6'h01);
    ticks(3);
    check("R8 prescaler cleared", count, 8'h00);
    ticks(1);
    check("R8 step after clear", count, 8'h01);

    // R5 sync latency and R4 rising edge
    setCtrl(6'h28);
    writeTmr(8'h00);
    @(negedge clk); extPin = 1'b1;
    idle(2);
    check("R5 not yet", count, 0);
    idle(1);
    check("R5 third edge", count, 1);
    idle(5);
    @(negedge clk); extPin = 1'b0;
    idle(6);
    check("R4 falling ignored in rising mode", count, 1);

    // R4 falling edge, tick ignored
    setCtrl(6'h38);
    writeTmr(8'h00);
    @(negedge clk); tickIn = 1'b1;
    @(negedge clk); extPin = 1'b1;
    idle(6);
    check("R4 rising ignored, tick ignored", count, 0);
    @(negedge clk); extPin = 1'b0;
    idle(6);
    check("R4 falling counted", count, 1);
    tickIn = 1'b0;

    // R9 undivided watchdog
    setCtrl(6'h00);
    @(negedge clk); wdtClr = 1'b1;
    @(negedge clk); wdtClr = 1'b0;
    ticks(255);
    check("R9 before terminal", wdtTimeout, 0);
    ticks(1);
    check("R9 timeout", wdtTimeout, 1);
    idle(1);
    check("R9 single cycle", wdtTimeout, 0);

    // R10 prescaled watchdog /4
    setCtrl(6'h22);
    @(negedge clk); wdtClr = 1'b1;
    @(negedge clk); wdtClr = 1'b0;
    ticks(1023);
    check("R10 before terminal", wdtTimeout, 0);
    ticks(1);
    check("R10 timeout", wdtTimeout, 1);

    // R11 clear wins over terminal step
    setCtrl(6'h00);
    @(negedge clk); wdtClr = 1'b1;
    @(negedge clk); wdtClr = 1'b0;
    ticks(255);
    @(negedge clk); tickIn = 1'b1; wdtClr = 1'b1;
    @(negedge clk); tickIn = 1'b0; wdtClr = 1'b0;
    check("R11 no timeout on clear", wdtTimeout, 0);
    ticks(255);
    check("R11 restarted", wdtTimeout, 0);
    ticks(1);
    check("R11 full period", wdtTimeout, 1);

    finishRun();
  end
endmodule